// File: doc/BRIEF.md
# Shared-Ramp Wilkinson Conversion Controller

This block is the digital back end of a multi-cell single-slope analog-to-digital converter. An array of analog storage cells, arranged as several channels of many cells each, samples continuously while the controller is in its write mode. A trigger ends sampling on every cell at once. It then starts one common voltage ramp together with one shared up-counter that runs on the conversion clock. Each cell has its own comparator. When that comparator first goes high, the cell stores the counter value as its code. All cells are therefore converted in one ramp cycle.

The comparator outputs are asynchronous to the conversion clock. Each one passes through a two-stage synchronizer, and the stored code is corrected for the fixed two-cycle synchronizer delay. Conversion ends in either of two cases: every cell has captured a code, or the ramp reaches full scale. At full scale, any cell that never fired is given the saturated code and an overflow flag. The controller then holds the codes in its read mode until an external read-done input arrives, and returns to write mode after that. Reading the codes out of the array is handled elsewhere.

The three operating modes are WRITE (sampling), CONVERT (ramp running) and READ (codes held). The named transitions are:
- start: WRITE to CONVERT, when the trigger is seen.
- finish: CONVERT to READ, on the all-fired or full-scale condition.
- release: READ to WRITE, when read-done is seen.

Top module: `wk_conv_ctrl`

## Requirements
- R1: After reset the block is in WRITE mode with every code and overflow flag at 0. Exactly one of `sampling_o`, `converting_o` and `reading_o` is high in every cycle.
- R2: A trigger sampled high in WRITE moves the block to CONVERT on that clock edge. The counter restarts at 0 and advances by one per cycle.
- R3: If a cell's comparator rises while the counter holds value V, the cell's code becomes V. Cell c's code is at `codes_o[c*CODE_W +: CODE_W]`, where c = channel*CELLS_PER_CH + cell.
- R4: Only the first rising edge of a comparator in a conversion is captured. Later falls and rises in the same conversion leave the code unchanged.
- R5: A cell that has not fired by full scale gets code 2^CODE_W-1 (4095 for 12 bits) and its bit in `ovf_o` is set to 1. Without an early finish, `reading_o` rises 2^CODE_W+2 clock edges after the trigger edge (4098 for 12 bits).
- R6: Once every cell has captured a code, the block finishes early. If the last comparator rises while the counter holds V, `reading_o` rises V+4 edges after the trigger edge.
- R7: A trigger in CONVERT or READ is ignored. It neither changes the mode nor alters the timing of the conversion.
- R8: Read-done in READ returns the block to WRITE on the next edge. Read-done in WRITE or CONVERT has no effect.
- R9: Codes and overflow flags hold their values through READ and the following WRITE. The next trigger clears them to 0.
- R10: A comparator that rises while the counter holds full scale is captured as 2^CODE_W-1 with no overflow flag, even though the conversion times out on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger: ends sampling and starts conversion |
| read_done_i | input | 1 | Readout finished, return to sampling |
| cmp_i | input | NUM_CH*CELLS_PER_CH | Asynchronous per-cell comparator outputs |
| sampling_o | output | 1 | WRITE mode: cells sample |
| converting_o | output | 1 | CONVERT mode: ramp and counter run |
| reading_o | output | 1 | READ mode: codes valid for readout |
| codes_o | output | NUM_CH*CELLS_PER_CH*CODE_W | Captured code per cell |
| ovf_o | output | NUM_CH*CELLS_PER_CH | Per-cell saturation flag |

## Verification
Two events can fall on the same clock edge here: a cell capturing its code, and the full-scale time-out that saturates unfired cells. The bench provokes this by holding one comparator low until the counter reaches full scale and raising it in that cycle. The other comparators fire early. It then expects that cell to read full scale with its overflow flag clear, and expects `reading_o` to rise exactly at the time-out edge. A second case times the all-fired early finish against the counter, so the two ways of ending a conversion are checked separately.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE   = 2'd0,
        MODE_CONVERT = 2'd1,
        MODE_READ    = 2'd2
    } wk_mode_e;

    // cycles from an asynchronous comparator edge to the capture edge
    localparam int SYNC_LAT = 2;
endpackage

// File: rtl/wk_mode_fsm.sv
module wk_mode_fsm
    import wk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic read_done,
    input  logic at_end,
    input  logic all_fired,
    output logic sampling,
    output logic converting,
    output logic reading,
    output logic start,
    output logic finish
);
    wk_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_WRITE:   if (trig)                  state_d = MODE_CONVERT;
            MODE_CONVERT: if (at_end || all_fired)   state_d = MODE_READ;
            MODE_READ:    if (read_done)             state_d = MODE_WRITE;
            default:                                 state_d = MODE_WRITE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_WRITE;
        else        state_q <= state_d;
    end

    always_comb begin
        sampling   = 1'b0;
        converting = 1'b0;
        reading    = 1'b0;
        start      = 1'b0;
        finish     = 1'b0;
        unique case (state_q)
            MODE_WRITE: begin
                sampling = 1'b1;
                start    = trig;
            end
            MODE_CONVERT: begin
                converting = 1'b1;
                finish     = at_end || all_fired;
            end
            MODE_READ:   reading  = 1'b1;
            default:     sampling = 1'b1;
        endcase
    end
endmodule

// File: rtl/wk_ramp_counter.sv
module wk_ramp_counter #(
    parameter int CNT_W   = 13,
    parameter int END_VAL = 4097
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end
);
    localparam logic [CNT_W-1:0] END_V = CNT_W'(END_VAL);

    assign at_end = (cnt == END_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (clear)            cnt <= '0;
        else if (en && !at_end)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wk_cell_capture.sv
module wk_cell_capture
    import wk_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              finish,
    input  logic              cmp_async,
    input  logic [CNT_W-1:0]  cnt,
    output logic [CODE_W-1:0] code,
    output logic              ovf,
    output logic              fired
);
    localparam logic [CNT_W-1:0]  LAT_V = CNT_W'(SYNC_LAT);
    localparam logic [CODE_W-1:0] FULL  = '1;

    logic s1, s2, s3;
    logic rise;
    logic [CNT_W-1:0] adj;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) {s3, s2, s1} <= 3'b000;
        else        {s3, s2, s1} <= {s2, s1, cmp_async};
    end

    assign rise = s2 && !s3;
    assign adj  = (cnt >= LAT_V) ? (cnt - LAT_V) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fired <= 1'b0;
            code  <= '0;
            ovf   <= 1'b0;
        end else if (start) begin
            fired <= 1'b0;
            code  <= '0;
            ovf   <= 1'b0;
        end else if (active && rise && !fired) begin
            fired <= 1'b1;
            code  <= adj[CODE_W-1:0];
        end else if (finish && !fired) begin
            code  <= FULL;
            ovf   <= 1'b1;
        end
    end
endmodule

// File: rtl/wk_conv_ctrl.sv
module wk_conv_ctrl
    import wk_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int CELLS_PER_CH = 256,
    parameter int CODE_W       = 12
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    trig_i,
    input  logic                                    read_done_i,
    input  logic [NUM_CH*CELLS_PER_CH-1:0]          cmp_i,
    output logic                                    sampling_o,
    output logic                                    converting_o,
    output logic                                    reading_o,
    output logic [NUM_CH*CELLS_PER_CH*CODE_W-1:0]   codes_o,
    output logic [NUM_CH*CELLS_PER_CH-1:0]          ovf_o
);
    localparam int NCELL   = NUM_CH * CELLS_PER_CH;
    localparam int CNT_W   = CODE_W + 1;
    localparam int END_VAL = (1 << CODE_W) - 1 + SYNC_LAT;

    logic             start, finish, at_end, all_fired;
    logic [CNT_W-1:0] ramp_cnt;
    logic [NCELL-1:0] fired_vec;

    assign all_fired = &fired_vec;

    wk_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig_i),
        .read_done  (read_done_i),
        .at_end     (at_end),
        .all_fired  (all_fired),
        .sampling   (sampling_o),
        .converting (converting_o),
        .reading    (reading_o),
        .start      (start),
        .finish     (finish)
    );

    wk_ramp_counter #(.CNT_W(CNT_W), .END_VAL(END_VAL)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .en     (converting_o),
        .cnt    (ramp_cnt),
        .at_end (at_end)
    );

    for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
        wk_cell_capture #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start),
            .active    (converting_o),
            .finish    (finish),
            .cmp_async (cmp_i[gi]),
            .cnt       (ramp_cnt),
            .code      (codes_o[gi*CODE_W +: CODE_W]),
            .ovf       (ovf_o[gi]),
            .fired     (fired_vec[gi])
        );
    end
endmodule

// File: rtl/wk_conv_ctrl_chk.sv
module wk_conv_ctrl_chk #(
    parameter int NCELL  = 4,
    parameter int CODE_W = 12,
    parameter int CNT_W  = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    trig_i,
    input logic                    read_done_i,
    input logic                    sampling_o,
    input logic                    converting_o,
    input logic                    reading_o,
    input logic [NCELL*CODE_W-1:0] codes_o,
    input logic [NCELL-1:0]        ovf_o,
    input logic [CNT_W-1:0]        ramp_cnt
);
    localparam logic [CNT_W-1:0]  CNT_END = CNT_W'((1 << CODE_W) + 1);
    localparam logic [CODE_W-1:0] FULL    = '1;

    // R1
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({sampling_o, converting_o, reading_o}));

    // R2
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling_o && trig_i) |=> (converting_o && ramp_cnt == '0));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        converting_o |-> (ramp_cnt <= CNT_END));

    // R7
    trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reading_o && trig_i && !read_done_i) |=> reading_o);

    // R8
    read_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reading_o && read_done_i) |=> sampling_o);

    // R8
    done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling_o && read_done_i && !trig_i) |=> sampling_o);

    // R9
    hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reading_o && !read_done_i) |=> ($stable(codes_o) && $stable(ovf_o)));

    // R9
    hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling_o && !trig_i) |=> ($stable(codes_o) && $stable(ovf_o)));

    for (genvar gi = 0; gi < NCELL; gi++) begin : g_ovf
        // R5
        ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_o[gi] |-> (codes_o[gi*CODE_W +: CODE_W] == FULL));
    end
endmodule

bind wk_conv_ctrl wk_conv_ctrl_chk #(
    .NCELL  (NUM_CH * CELLS_PER_CH),
    .CODE_W (CODE_W),
    .CNT_W  (CODE_W + 1)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .read_done_i  (read_done_i),
    .sampling_o   (sampling_o),
    .converting_o (converting_o),
    .reading_o    (reading_o),
    .codes_o      (codes_o),
    .ovf_o        (ovf_o),
    .ramp_cnt     (ramp_cnt)
);

// File: tb/test_wk_conv_ctrl.sv
`timescale 1ns/1ps
module test_wk_conv_ctrl;
    localparam int NUM_CH = 2;
    localparam int CPC    = 2;
    localparam int NC     = NUM_CH * CPC;
    localparam int CW     = 12;
    localparam int FULLV  = (1 << CW) - 1;
    localparam int TOUT   = (1 << CW) + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_i = 1'b0;
    logic              read_done_i = 1'b0;
    logic [NC-1:0]     cmp_i = '0;
    logic              sampling_o, converting_o, reading_o;
    logic [NC*CW-1:0]  codes_o;
    logic [NC-1:0]     ovf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wk_conv_ctrl #(.NUM_CH(NUM_CH), .CELLS_PER_CH(CPC), .CODE_W(CW)) i_wk_conv_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .read_done_i(read_done_i),
        .cmp_i(cmp_i), .sampling_o(sampling_o), .converting_o(converting_o),
        .reading_o(reading_o), .codes_o(codes_o), .ovf_o(ovf_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int c);
        return int'(codes_o[c*CW +: CW]);
    endfunction

    // rise[i] < 0: never fires; drop/rerise give a later glitch on cell gl
    task automatic run_conv(input int rise[NC], input int gl, input int drop_k,
                            input int rerise_k, input int trig_k, input int done_k,
                            output int edges);
        int k;
        @(negedge clk);
        trig_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trig_i = 1'b0;
        k = 0;
        edges = -1;
        while (k < TOUT + 50) begin
            if (reading_o) begin
                edges = k;
                break;
            end
            for (int i = 0; i < NC; i++)
                if (rise[i] == k) cmp_i[i] = 1'b1;
            if (gl >= 0 && k == drop_k)   cmp_i[gl] = 1'b0;
            if (gl >= 0 && k == rerise_k) cmp_i[gl] = 1'b1;
            trig_i      = (k == trig_k);
            read_done_i = (k == done_k);
            @(posedge clk);
            @(negedge clk);
            trig_i      = 1'b0;
            read_done_i = 1'b0;
            k++;
        end
    endtask

    task automatic lower_all;
        @(negedge clk);
        cmp_i = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 sampling after reset", int'(sampling_o), 1);
        check("R1 modes one-hot", int'(sampling_o) + int'(converting_o) + int'(reading_o), 1);
        check("R1 codes zero", int'(codes_o != '0), 0);
        check("R1 ovf zero", int'(ovf_o), 0);
        read_done_i = 1'b1;
        @(negedge clk);
        read_done_i = 1'b0;
        check("R8 read-done ignored in write", int'(sampling_o), 1);
    endtask

    task automatic t_capture;
        int r[NC];
        int e;
        r = '{0, 5, 100, 2000};
        lower_all();
        @(negedge clk);
        trig_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 converting after trigger", int'(converting_o), 1);
        trig_i = 1'b0;
        // release and restart via a full run from here
        wait_read_then_release();
        lower_all();
        run_conv(r, -1, 0, 0, -1, -1, e);
        check("R6 early finish edge count", e, 2004);
        check("R3 code cell0 V=0", code_of(0), 0);
        check("R3 code cell1 V=5", code_of(1), 5);
        check("R3 code cell2 V=100", code_of(2), 100);
        check("R3 code cell3 V=2000", code_of(3), 2000);
        check("R5 no overflow when all fire", int'(ovf_o), 0);
        @(negedge clk);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        check("R7 trigger ignored in read", int'(reading_o), 1);
        check("R9 codes held in read", code_of(2), 100);
        read_done_i = 1'b1;
        @(negedge clk);
        read_done_i = 1'b0;
        check("R8 release to write", int'(sampling_o), 1);
        check("R9 codes held in write", code_of(3), 2000);
    endtask

    task automatic wait_read_then_release;
        int n = 0;
        while (!reading_o && n < TOUT + 50) begin
            @(negedge clk);
            n++;
        end
        read_done_i = 1'b1;
        @(negedge clk);
        read_done_i = 1'b0;
    endtask

    task automatic t_saturate;
        int r[NC];
        int e;
        r = '{7, 300, 50, -1};
        lower_all();
        run_conv(r, 2, 55, 60, 120, 130, e);
        check("R5 time-out edge count", e, TOUT);
        check("R7 trigger in convert kept timing", e, TOUT);
        check("R8 read-done in convert ignored", int'(reading_o), 1);
        check("R3 code cell0 V=7", code_of(0), 7);
        check("R3 code cell1 V=300", code_of(1), 300);
        check("R4 later edge ignored", code_of(2), 50);
        check("R5 saturated code", code_of(3), FULLV);
        check("R5 overflow flags", int'(ovf_o), 8);
        @(negedge clk);
        read_done_i = 1'b1;
        @(negedge clk);
        read_done_i = 1'b0;
    endtask

    task automatic t_collision;
        int r[NC];
        int e;
        r = '{10, 20, 30, FULLV};
        lower_all();
        run_conv(r, -1, 0, 0, -1, -1, e);
        check("R10 finish on time-out edge", e, TOUT);
        check("R10 late capture code", code_of(3), FULLV);
        check("R10 no overflow on late capture", int'(ovf_o), 0);
        check("R3 code cell1 V=20", code_of(1), 20);
        @(negedge clk);
        read_done_i = 1'b1;
        @(negedge clk);
        read_done_i = 1'b0;
        check("R9 codes held after release", code_of(0), 10);
        cmp_i = '0;
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        check("R9 trigger clears codes", int'(codes_o != '0), 0);
        check("R2 converting", int'(converting_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture();
        t_saturate();
        t_collision();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule